// File: doc/BRIEF.md
# Pipelined 48-bit Multiply-Accumulate Unit

This unit is the arithmetic core for convolution kernels. It takes two 32-bit operands on each cycle and extends each to 48 bits, with sign or zero extension chosen per operation. It multiplies them and adds the product to a 48-bit accumulator, or subtracts it. A clear operation restarts the sum at zero. A read operation reduces the accumulator to 32 bits in one of three ways and returns the result.

The datapath has five register stages and accepts a new operation on every cycle, with no stall. Operations act on the accumulator in the order they are issued. A read returns the accumulator as it stands after every operation issued before it. A sticky flag reports that the 48-bit sum has wrapped. The flag stays set until the next clear.

Top module: `mac48_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data` and `ovf` are all 0.
- R2: An accepted operation with `op_code` 2'b00 adds the low 48 bits of (ext(a) × ext(b)) to the accumulator. ext() sign-extends when `op_signed` is 1 and zero-extends when it is 0.
- R3: `op_code` 2'b01 subtracts the same 48-bit product from the accumulator, modulo 2^48.
- R4: `op_code` 2'b10 sets the accumulator and `ovf` to zero. An operation issued on the very next cycle accumulates from zero.
- R5: `op_code` 2'b11 is a read. It leaves the accumulator unchanged. For a read accepted at a rising edge, `out_valid` is high for exactly one cycle, after the fifth rising edge counted from and including the accepting one. `out_data` then reflects every operation issued before the read.
- R6: A read with `op_rmode` 2'b00 or 2'b11 (truncate) returns accumulator bits 31:0.
- R7: A read with `op_rmode` 2'b01 (round) returns bits 47:16 of (accumulator + 2^15), computed without wrap into a 49th bit.
- R8: A read with `op_rmode` 2'b10 (saturate) treats the accumulator as signed. It returns 0x7FFFFFFF above 2^31-1, 0x80000000 below -2^31, and bits 31:0 otherwise.
- R9: `ovf` goes high when a signed accumulate or subtract overflows the signed 48-bit range. It also goes high when an unsigned accumulate carries out of bit 47, or an unsigned subtract borrows. It then stays high until a clear.
- R10: One operation is accepted per cycle while `op_valid` is high. A cycle with `op_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00 accumulate, 01 subtract, 10 clear, 11 read |
| op_signed | input | 1 | 1 selects sign extension of the operands |
| op_rmode | input | 2 | Read reduction: 00/11 truncate, 01 round, 10 saturate |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Read result strobe |
| out_data | output | 32 | Reduced read result |
| ovf | output | 1 | Sticky accumulator wrap flag |

## Verification
The bench drives a clear immediately followed by an accumulate. A unit that lets the clear lose against the in-flight operation would return a stale sum there. Unsigned all-ones products are accumulated until bit 47 carries out, followed by a clear. This catches a flag that never sets, one that forgets the signedness, and one that survives the clear. Reads in all three reduction modes are placed on values just across the rounding half-point and beyond both signed 32-bit limits. An off-by-one rounding bias or a swapped clamp limit therefore shows up directly. A back-to-back random mix of all four operations checks the five-cycle read latency and the in-order behaviour of the accumulator under full throughput.

// File: rtl/mac48_unit.sv
module mac48_unit #(
  parameter int OPW  = 32,
  parameter int ACW  = 48,
  parameter int FRAC = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [1:0]     op_code,
  input  logic           op_signed,
  input  logic [1:0]     op_rmode,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic           out_valid,
  output logic [OPW-1:0] out_data,
  output logic           ovf
);
  localparam int EXT = ACW - OPW;
  localparam logic [ACW:0] HALF = (ACW+1)'(1) << (FRAC-1);
  localparam logic [OPW-1:0] SMAX = {1'b0, {(OPW-1){1'b1}}};
  localparam logic [OPW-1:0] SMIN = {1'b1, {(OPW-1){1'b0}}};

  logic           s1_v, s1_sgn;
  logic [1:0]     s1_op, s1_rm;
  logic [ACW-1:0] s1_a, s1_b;
  logic           s2_v, s2_sgn;
  logic [1:0]     s2_op, s2_rm;
  logic [ACW-1:0] s2_prod;
  logic [ACW-1:0] acc;
  logic           s3_v;
  logic [1:0]     s3_rm;
  logic [ACW-1:0] s3_snap;
  logic           s4_v;
  logic [OPW-1:0] s4_data;

  wire            is_sub = s2_op[0];
  wire [ACW:0]    add_w  = {1'b0, acc} + {1'b0, s2_prod};
  wire [ACW:0]    sub_w  = {1'b0, acc} - {1'b0, s2_prod};
  wire [ACW:0]    res_w  = is_sub ? sub_w : add_w;
  wire            sa = acc[ACW-1], sp = s2_prod[ACW-1], sr = res_w[ACW-1];
  wire            s_ov = is_sub ? (sa != sp) && (sr != sa) : (sa == sp) && (sr != sa);
  wire            wrap = s2_sgn ? s_ov : res_w[ACW];

  wire [ACW:0]    rnd_w  = {1'b0, s3_snap} + HALF;
  wire [ACW-OPW:0] hi    = s3_snap[ACW-1:OPW-1];
  wire            fits   = (hi == '0) || (hi == '1);
  logic [OPW-1:0] red;

  always_comb begin
    unique case (s3_rm)
      2'b01:   red = rnd_w[FRAC+OPW-1:FRAC];
      2'b10:   red = fits ? s3_snap[OPW-1:0] : (s3_snap[ACW-1] ? SMIN : SMAX);
      default: red = s3_snap[OPW-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sgn <= 1'b0; s1_op <= '0; s1_rm <= '0; s1_a <= '0; s1_b <= '0;
      s2_v <= 1'b0; s2_sgn <= 1'b0; s2_op <= '0; s2_rm <= '0; s2_prod <= '0;
      acc <= '0; ovf <= 1'b0;
      s3_v <= 1'b0; s3_rm <= '0; s3_snap <= '0;
      s4_v <= 1'b0; s4_data <= '0;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      s1_v   <= op_valid;
      s1_op  <= op_code;
      s1_sgn <= op_signed;
      s1_rm  <= op_rmode;
      s1_a   <= op_signed ? {{EXT{op_a[OPW-1]}}, op_a} : {{EXT{1'b0}}, op_a};
      s1_b   <= op_signed ? {{EXT{op_b[OPW-1]}}, op_b} : {{EXT{1'b0}}, op_b};

      s2_v    <= s1_v;
      s2_op   <= s1_op;
      s2_sgn  <= s1_sgn;
      s2_rm   <= s1_rm;
      s2_prod <= s1_a * s1_b;

      s3_v  <= s2_v && (s2_op == 2'b11);
      s3_rm <= s2_rm;
      if (s2_v) begin
        unique case (s2_op)
          2'b00, 2'b01: begin
            acc <= res_w[ACW-1:0];
            if (wrap) ovf <= 1'b1;
          end
          2'b10: begin
            acc <= '0;
            ovf <= 1'b0;
          end
          default: s3_snap <= acc;
        endcase
      end

      s4_v    <= s3_v;
      s4_data <= s3_v ? red : '0;

      out_valid <= s4_v;
      out_data  <= s4_data;
    end
  end
endmodule

module mac48_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_code,
  input logic       out_valid,
  input logic       ovf
);
  p_rd_to_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b11) |=> ##4 out_valid);
  p_valid_from_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(op_valid && op_code == 2'b11, 5));
  p_ovf_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(op_valid && !op_code[1], 3));
  p_ovf_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(op_valid && op_code == 2'b10, 3));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid, 5) |-> !out_valid);
endmodule

bind mac48_unit mac48_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .out_valid(out_valid), .ovf(ovf)
);

// File: tb/mac48_unit_tb_top.sv
module mac48_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic        op_signed = 1'b0;
  logic [1:0]  op_rmode = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid, ovf;
  logic [31:0] out_data;

  int total = 0, bad = 0, cycles = 0;
  logic [47:0] m_acc = '0;
  logic        m_ovf = 1'b0;
  logic        ev [1:5];
  logic [31:0] ed [1:5];
  logic        eo [1:3];

  always #2 clk = ~clk;

  mac48_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_signed(op_signed), .op_rmode(op_rmode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_data(out_data), .ovf(ovf)
  );

  function automatic logic [47:0] ext(input logic [31:0] x, input logic s);
    return s ? {{16{x[31]}}, x} : {16'h0, x};
  endfunction

  function automatic logic [31:0] reduce(input logic [47:0] v, input logic [1:0] m);
    logic [48:0] r;
    if (m == 2'b01) begin
      r = {1'b0, v} + 49'h8000;
      return r[47:16];
    end
    if (m == 2'b10) begin
      if (!v[47] && v[47:31] != 17'h0) return 32'h7FFFFFFF;
      if (v[47] && v[47:31] != 17'h1FFFF) return 32'h80000000;
    end
    return v[31:0];
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic [1:0] c, input logic s, input logic [1:0] m,
                       input logic [31:0] a, input logic [31:0] b);
    logic [47:0] p, r;
    logic [48:0] w;
    logic rd, so;
    rd = v && c == 2'b11;
    for (int i = 5; i > 1; i--) begin ev[i] = ev[i-1]; ed[i] = ed[i-1]; end
    for (int i = 3; i > 1; i--) eo[i] = eo[i-1];
    ev[1] = rd;
    ed[1] = rd ? reduce(m_acc, m) : 32'h0;
    if (v && !c[1]) begin
      p = ext(a, s) * ext(b, s);
      w = c[0] ? {1'b0, m_acc} - {1'b0, p} : {1'b0, m_acc} + {1'b0, p};
      r = w[47:0];
      so = c[0] ? (m_acc[47] != p[47]) && (r[47] != m_acc[47])
                : (m_acc[47] == p[47]) && (r[47] != m_acc[47]);
      if (s ? so : w[48]) m_ovf = 1'b1;
      m_acc = r;
    end else if (v && c == 2'b10) begin
      m_acc = '0;
      m_ovf = 1'b0;
    end
    eo[1] = m_ovf;
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic s, input logic [1:0] m,
                      input logic [31:0] a, input logic [31:0] b, input string req);
    op_valid = v; op_code = c; op_signed = s; op_rmode = m; op_a = a; op_b = b;
    @(posedge clk);
    model(v, c, s, m, a, b);
    @(negedge clk);
    check({req, " valid R5"}, {47'h0, out_valid}, {47'h0, ev[5]});
    if (ev[5]) check({req, " data"}, {16'h0, out_data}, {16'h0, ed[5]});
    check({req, " ovf R9"}, {47'h0, ovf}, {47'h0, eo[3]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, 1'b0, 2'b00, 32'h0, 32'h0, "R10 idle");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 1; i <= 5; i++) begin ev[i] = 1'b0; ed[i] = '0; end
    for (int i = 1; i <= 3; i++) eo[i] = 1'b0;
    #1;
    @(negedge clk);
    check("R1 out_valid in reset", {47'h0, out_valid}, 48'h0);
    check("R1 out_data in reset", {16'h0, out_data}, 48'h0);
    check("R1 ovf in reset", {47'h0, ovf}, 48'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R4 clear then immediate accumulate; R2 signed accumulate, R6 truncate
    step(1, 2'b10, 0, 0, 0, 0, "R4");
    step(1, 2'b00, 1, 0, 32'hFFFFFFFD, 32'h00000007, "R2");
    step(1, 2'b11, 0, 2'b00, 0, 0, "R6 trunc neg");
    step(1, 2'b11, 0, 2'b11, 0, 0, "R6 trunc alt");
    // R3 subtract, R10 idle gap
    step(1, 2'b01, 0, 0, 32'h5, 32'h3, "R3");
    idle(1);
    step(1, 2'b11, 0, 2'b00, 0, 0, "R3 read");
    // R7 round around the half point
    step(1, 2'b10, 0, 0, 0, 0, "R4 clear");
    step(1, 2'b00, 1, 0, 32'h1, 32'h7FFF, "R7");
    step(1, 2'b11, 0, 2'b01, 0, 0, "R7 below half");
    step(1, 2'b00, 1, 0, 32'h1, 32'h1, "R7");
    step(1, 2'b11, 0, 2'b01, 0, 0, "R7 at half");
    // R8 saturate both directions
    step(1, 2'b10, 0, 0, 0, 0, "R4 clear");
    step(1, 2'b00, 0, 0, 32'h10000, 32'h10000, "R8");
    step(1, 2'b11, 0, 2'b10, 0, 0, "R8 high clamp");
    step(1, 2'b01, 1, 0, 32'h20000, 32'h10000, "R8");
    step(1, 2'b11, 0, 2'b10, 0, 0, "R8 low clamp");
    step(1, 2'b11, 0, 2'b00, 0, 0, "R5 read keeps acc");
    // R9 unsigned carry out, sticky, then clear
    step(1, 2'b10, 0, 0, 0, 0, "R4 clear");
    for (int i = 0; i < 3; i++) step(1, 2'b00, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R9 wrap");
    idle(4);
    step(1, 2'b00, 0, 0, 32'h1, 32'h1, "R9 sticky");
    idle(3);
    step(1, 2'b10, 0, 0, 0, 0, "R4 ovf clear");
    step(1, 2'b11, 0, 2'b00, 0, 0, "R4 read zero");
    idle(5);

    // random mix, back to back (R10)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      logic [1:0] rc;
      int sel = $urandom_range(0, 9);
      rc = sel < 4 ? 2'b00 : sel < 6 ? 2'b01 : sel < 7 ? 2'b10 : 2'b11;
      ra = $urandom_range(0, 1) ? $urandom : $urandom_range(0, 32'h3FFFF);
      rb = $urandom_range(0, 1) ? $urandom : $urandom_range(0, 32'h3FFFF);
      step($urandom_range(0, 7) != 0, rc, 1'($urandom), 2'($urandom), ra, rb, "R2 random");
    end
    idle(6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule